// File: doc/BRIEF.md
# Ethernet Transmit Pacing Controller

This block decides, clock by clock, when the transmit side of a 10/100 MAC may put something on its nibble interface. It sits between a transmit frame buffer and the serialiser. A frame waiting in the buffer gets a one-cycle grant strobe. A pending pause request gets a one-cycle pause-launch strobe with the pause time value beside it. Receive-buffer back pressure in half duplex drives a jam level. Serialisation, CRC, collision backoff and the PHY are handled elsewhere.

Every transmission is followed by an idle gap whose length comes from a 4-bit gap code. The gap is counted in clocks of four bit times (25 MHz nibble rate), rounded up to whole clocks. A jabber guard cuts off frames that reach the configured byte limit unless it is switched off. Two pause request bits are set by one-cycle strobes. Each bit clears itself when its own pause frame ends. When both are pending, the all-ones request is served before the all-zeros one, and both go before any waiting data frame.

Top module: `tx_pace_ctrl`

## Requirements
- R1: After reset no start strobe, jam or truncation is active and both pause bits read 0. A frame offered right after reset is granted in the first cycle it is offered.
- R2: A gap code with bit 3 equal to 0 gives a 96-bit gap. The first start strobe comes 25 clocks after the clock in which the transmission ended (24 idle clocks between them).
- R3: Gap codes 1000b to 1111b give 64 + 8*k bit times (k = code bits 2:0), which is 16 + 2*k idle clocks. Code 1111b gives 120 bit times.
- R4: A grant lasts one clock, and no further start strobe appears until the transmission ends. A frame-end pulse outside a transmission is ignored and starts no gap.
- R5: With jabber protection on (jab_dis_i = 0), a frame that reaches JAB_BYTES*2 nibble clocks without a frame end gets trunc_o in its last allowed nibble clock. That clock ends the frame, and a normal gap follows.
- R6: With jab_dis_i = 1, no truncation occurs, whatever the frame length.
- R7: A set strobe raises its pause bit in the next clock. The bit clears in the clock after the frame end of its own pause frame. A launch of the all-zeros request shows pause_val_o = 0000h, and a launch of the all-ones request shows FFFFh.
- R8: A pending pause request waits for the current transmission and its gap. It is then launched in place of a waiting data frame.
- R9: With both pause bits set, the FFFFh frame goes first and the 0000h frame follows after a further full gap.
- R10: In half duplex (full_duplex_i = 0), once the gap has ended and rx_free_i < hw_thresh_i, jam_o rises in the next clock and no start strobe is given while it is high. When the free space recovers, jam_o falls and a full gap runs before the next grant.
- R11: In full duplex, low receive free space causes no jam and does not hold back grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Nibble clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gap_code_i | input | 4 | Inter-frame gap select code |
| jab_dis_i | input | 1 | 1 disables the jabber cut-off |
| full_duplex_i | input | 1 | 1 for full duplex, 0 for half duplex |
| frm_avail_i | input | 1 | Transmit buffer holds a frame ready to start |
| frm_end_i | input | 1 | Last nibble of the current transmission is on the line |
| pause_zero_set_i | input | 1 | One-cycle strobe requesting a pause frame with time 0000h |
| pause_max_set_i | input | 1 | One-cycle strobe requesting a pause frame with time FFFFh |
| rx_free_i | input | FREE_W | Free space of the receive buffer in bytes |
| hw_thresh_i | input | FREE_W | Back-pressure threshold in bytes (3072 is the usual setting) |
| grant_o | output | 1 | One-cycle start strobe for a data frame |
| pause_go_o | output | 1 | One-cycle start strobe for a pause frame |
| pause_val_o | output | PAUSE_W | Pause time value for the launched pause frame |
| jam_o | output | 1 | Back-pressure jam pattern enable |
| trunc_o | output | 1 | Frame cut off by the jabber guard in this clock |
| pend_zero_o | output | 1 | 0000h pause request pending |
| pend_max_o | output | 1 | FFFFh pause request pending |

## Verification
The bench builds the block with JAB_BYTES = 32, so the cut-off falls at the 64th nibble clock. A directed run can then hit the exact truncation clock and still check that a 100-nibble frame passes untouched when the guard is off. All other parameters keep their defaults: four bit times per clock, a 12-bit free-space count and 16-bit pause values. The gap codes can therefore be measured to the exact clock, and a 3072-byte threshold can be placed against free-space counts on either side of it.

// File: rtl/tx_pace_pkg.sv
package tx_pace_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_PZERO,
    ST_PMAX,
    ST_JAM
  } line_st_e;

  localparam int unsigned MAX_GAP_BITS = 120;
  localparam int unsigned MIN_GAP_BITS = 64;

  // msb clear selects the fixed 96-bit gap; otherwise 64 + 8*k
  function automatic int unsigned gap_bits(input logic [3:0] code);
    if (!code[3]) return 96;
    return MIN_GAP_BITS + 8 * int'(code[2:0]);
  endfunction

endpackage

// File: rtl/tx_gap_timer.sv
module tx_gap_timer #(
  parameter int unsigned BITS_PER_CLK = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] code_i,
  input  logic       load_i,
  output logic       done_o
);
  import tx_pace_pkg::*;

  localparam int unsigned MAX_CLKS = (MAX_GAP_BITS + BITS_PER_CLK - 1) / BITS_PER_CLK;
  localparam int unsigned CW       = $clog2(MAX_CLKS + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_val;

  always_comb begin
    load_val = CW'((gap_bits(code_i) + BITS_PER_CLK - 1) / BITS_PER_CLK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R2: a fresh gap is never already complete
  p_gap_starts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !done_o);

endmodule

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard #(
  parameter int unsigned LIMIT_NIB = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic end_i,
  input  logic jab_dis_i,
  output logic trunc_o
);
  localparam int unsigned NW = $clog2(LIMIT_NIB);
  localparam logic [NW-1:0] LAST = NW'(LIMIT_NIB - 1);

  logic [NW-1:0] nib_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             nib_q <= '0;
    else if (!active_i)      nib_q <= '0;
    else if (nib_q != LAST)  nib_q <= nib_q + 1'b1;
  end

  assign trunc_o = active_i && !jab_dis_i && !end_i && (nib_q == LAST);

  // R5: a cut-off only happens inside a frame that was already running
  p_trunc_in_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trunc_o |-> $past(active_i));

endmodule

// File: rtl/tx_pause_req.sv
module tx_pause_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_zero_i,
  input  logic set_max_i,
  input  logic done_zero_i,
  input  logic done_max_i,
  output logic pend_zero_o,
  output logic pend_max_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_zero_o <= 1'b0;
      pend_max_o  <= 1'b0;
    end else begin
      if (set_zero_i)       pend_zero_o <= 1'b1;
      else if (done_zero_i) pend_zero_o <= 1'b0;
      if (set_max_i)        pend_max_o  <= 1'b1;
      else if (done_max_i)  pend_max_o  <= 1'b0;
    end
  end

  // R7: a bit only drops when its own pause frame has finished
  p_max_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_max_o) |-> $past(done_max_i));
  p_zero_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_zero_o) |-> $past(done_zero_i));

endmodule

// File: rtl/tx_pace_ctrl.sv
module tx_pace_ctrl #(
  parameter int unsigned BITS_PER_CLK = 4,
  parameter int unsigned JAB_BYTES    = 2048,
  parameter int unsigned NIB_PER_BYTE = 2,
  parameter int unsigned FREE_W       = 12,
  parameter int unsigned PAUSE_W      = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [3:0]         gap_code_i,
  input  logic               jab_dis_i,
  input  logic               full_duplex_i,
  input  logic               frm_avail_i,
  input  logic               frm_end_i,
  input  logic               pause_zero_set_i,
  input  logic               pause_max_set_i,
  input  logic [FREE_W-1:0]  rx_free_i,
  input  logic [FREE_W-1:0]  hw_thresh_i,
  output logic               grant_o,
  output logic               pause_go_o,
  output logic [PAUSE_W-1:0] pause_val_o,
  output logic               jam_o,
  output logic               trunc_o,
  output logic               pend_zero_o,
  output logic               pend_max_o
);
  import tx_pace_pkg::*;

  localparam int unsigned LIMIT_NIB    = JAB_BYTES * NIB_PER_BYTE;
  localparam int unsigned MIN_GAP_CLKS = (MIN_GAP_BITS + BITS_PER_CLK - 1) / BITS_PER_CLK;

  line_st_e st_q, st_d;
  logic     gap_done, gap_load, bp, launch, in_tx, tx_end;
  logic     done_zero, done_max, pend_any;

  tx_gap_timer #(.BITS_PER_CLK(BITS_PER_CLK)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (gap_code_i),
    .load_i (gap_load),
    .done_o (gap_done)
  );

  tx_jabber_guard #(.LIMIT_NIB(LIMIT_NIB)) u_jab (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (in_tx),
    .end_i     (frm_end_i),
    .jab_dis_i (jab_dis_i),
    .trunc_o   (trunc_o)
  );

  tx_pause_req u_pause (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_zero_i  (pause_zero_set_i),
    .set_max_i   (pause_max_set_i),
    .done_zero_i (done_zero),
    .done_max_i  (done_max),
    .pend_zero_o (pend_zero_o),
    .pend_max_o  (pend_max_o)
  );

  assign bp       = !full_duplex_i && (rx_free_i < hw_thresh_i);
  assign in_tx    = (st_q == ST_FRAME) || (st_q == ST_PZERO) || (st_q == ST_PMAX);
  assign tx_end   = in_tx && (frm_end_i || trunc_o);
  assign pend_any = pend_zero_o || pend_max_o;
  assign launch   = (st_q == ST_IDLE) && gap_done && !bp;

  assign pause_go_o  = launch && pend_any;
  assign pause_val_o = pend_max_o ? {PAUSE_W{1'b1}} : {PAUSE_W{1'b0}};
  assign grant_o     = launch && !pend_any && frm_avail_i;
  assign jam_o       = (st_q == ST_JAM);

  assign done_zero = (st_q == ST_PZERO) && tx_end;
  assign done_max  = (st_q == ST_PMAX)  && tx_end;
  assign gap_load  = tx_end || ((st_q == ST_JAM) && !bp);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (gap_done && bp)   st_d = ST_JAM;
        else if (pause_go_o)  st_d = pend_max_o ? ST_PMAX : ST_PZERO;
        else if (grant_o)     st_d = ST_FRAME;
      end
      ST_FRAME, ST_PZERO, ST_PMAX: if (tx_end) st_d = ST_IDLE;
      ST_JAM:                  if (!bp)   st_d = ST_IDLE;
      default:                            st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // ---- assertions ----
  logic [7:0] idle_run_q;
  logic       seen_end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_run_q <= '0;
      seen_end_q <= 1'b0;
    end else if (gap_load) begin
      idle_run_q <= '0;
      seen_end_q <= 1'b1;
    end else if (!in_tx && !jam_o && idle_run_q != 8'hFF) begin
      idle_run_q <= idle_run_q + 1'b1;
    end
  end

  // R3: never fewer idle clocks than the shortest selectable gap
  p_min_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant_o || pause_go_o) && seen_end_q) |-> (idle_run_q >= 8'(MIN_GAP_CLKS)));

  // R4: start strobes are single-cycle and mutually exclusive
  p_one_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grant_o, pause_go_o}));
  p_grant_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !grant_o && !pause_go_o);

  // R8: no data frame while a pause request is waiting
  p_pause_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> !pend_zero_o && !pend_max_o);

  // R10: jam only begins in half duplex
  p_jam_half_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(jam_o) |-> $past(!full_duplex_i));

endmodule

// File: tb/tx_pace_ctrl_tb.sv
module tx_pace_ctrl_tb_top;

  localparam int unsigned JAB_BYTES = 32;
  localparam int unsigned FREE_W    = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [3:0]        gap_code;
  logic              jab_dis, full_dup, avail, fend, set_z, set_m;
  logic [FREE_W-1:0] rx_free, thresh;
  logic              grant, pgo, jam, trunc, pz, pm;
  logic [15:0]       pval;

  int n_chk = 0;
  int n_bad = 0;
  bit start_in_busy;

  always #2.5 clk = ~clk;

  tx_pace_ctrl #(.JAB_BYTES(JAB_BYTES), .FREE_W(FREE_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .gap_code_i(gap_code), .jab_dis_i(jab_dis),
    .full_duplex_i(full_dup), .frm_avail_i(avail), .frm_end_i(fend),
    .pause_zero_set_i(set_z), .pause_max_set_i(set_m), .rx_free_i(rx_free),
    .hw_thresh_i(thresh), .grant_o(grant), .pause_go_o(pgo), .pause_val_o(pval),
    .jam_o(jam), .trunc_o(trunc), .pend_zero_o(pz), .pend_max_o(pm));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gap_clks(input logic [3:0] c);
    if (!c[3]) return 24;
    return 16 + 2 * int'(c[2:0]);
  endfunction

  // counts clocks from the current one until a start strobe is seen
  task automatic wait_start(output int c);
    c = 1;
    #1;
    while (!(grant || pgo) && c < 300) begin
      @(negedge clk); #1;
      c++;
    end
  endtask

  // current clock holds a start strobe; run n nibble clocks
  task automatic send_frame(input int n, input bit sz, input bit sm);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      set_z = (k == 0) ? sz : 1'b0;
      set_m = (k == 0) ? sm : 1'b0;
      fend  = (k == n - 1);
      #1;
      if (grant || pgo) start_in_busy = 1'b1;
    end
    @(negedge clk);
    fend = 1'b0; set_z = 1'b0; set_m = 1'b0;
  endtask

  task automatic settle();
    avail = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic t_reset();
    int c;
    chk(!grant && !pgo && !jam && !trunc, "R1 outputs idle", {grant, pgo, jam, trunc}, 0);
    chk(!pz && !pm, "R1 pause bits", {pz, pm}, 0);
    avail = 1'b1;
    wait_start(c);
    chk(grant && c == 1, "R1 first grant", c, 1);
    send_frame(6, 0, 0);
    settle();
  endtask

  task automatic t_gap(input logic [3:0] code, input string req);
    int c;
    gap_code = code;
    avail = 1'b1;
    wait_start(c);
    send_frame(6, 0, 0);
    wait_start(c);
    chk(grant && c == gap_clks(code) + 1, req, c, gap_clks(code) + 1);
    send_frame(6, 0, 0);
    settle();
  endtask

  task automatic t_busy_ignore();
    int c;
    start_in_busy = 1'b0;
    @(negedge clk); fend = 1'b1;
    @(negedge clk); fend = 1'b0; avail = 1'b1;
    wait_start(c);
    chk(grant && c == 1, "R4 stray frame end starts no gap", c, 1);
    send_frame(20, 0, 0);
    chk(!start_in_busy, "R4 no start strobe during a frame", start_in_busy, 0);
    settle();
  endtask

  task automatic t_jabber_on();
    int c, k;
    jab_dis = 1'b0;
    avail = 1'b1;
    wait_start(c);
    k = 0;
    @(negedge clk); #1;
    while (!trunc && k < 200) begin
      @(negedge clk); #1;
      k++;
    end
    chk(k == JAB_BYTES * 2 - 1, "R5 truncation clock", k, JAB_BYTES * 2 - 1);
    @(negedge clk);
    wait_start(c);
    chk(grant && c == gap_clks(gap_code) + 1, "R5 gap after truncation", c, gap_clks(gap_code) + 1);
    send_frame(6, 0, 0);
    settle();
  endtask

  task automatic t_jabber_off();
    int c;
    bit seen;
    jab_dis = 1'b1;
    avail = 1'b1;
    seen = 1'b0;
    wait_start(c);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      fend = (k == 99);
      #1;
      if (trunc) seen = 1'b1;
    end
    @(negedge clk); fend = 1'b0;
    chk(!seen, "R6 no truncation when disabled", seen, 0);
    jab_dis = 1'b0;
    settle();
  endtask

  task automatic t_pause();
    int c, g;
    g = gap_clks(gap_code);
    avail = 1'b1;
    wait_start(c);
    send_frame(8, 1, 1);
    chk(pz && pm, "R7 set strobes raise both bits", {pz, pm}, 3);
    wait_start(c);
    chk(pgo && !grant && c == g + 1, "R8 pause waits for gap and beats data", c, g + 1);
    chk(pval == 16'hFFFF, "R9 FFFFh served first", pval, 16'hFFFF);
    send_frame(4, 0, 0);
    #1;
    chk(!pm && pz, "R7 only FFFFh bit cleared", {pz, pm}, 2);
    wait_start(c);
    chk(pgo && c == g + 1, "R9 second pause after full gap", c, g + 1);
    chk(pval == 16'h0000, "R7 zero pause value", pval, 0);
    send_frame(4, 0, 0);
    #1;
    chk(!pz && !pm, "R7 zero bit cleared", {pz, pm}, 0);
    wait_start(c);
    chk(grant && c == g + 1, "R8 data frame after pauses", c, g + 1);
    send_frame(6, 0, 0);
    settle();
  endtask

  task automatic t_jam_half();
    int c;
    bit granted;
    full_dup = 1'b0;
    @(negedge clk); rx_free = 12'd100; #1;
    chk(!jam, "R10 jam registered", jam, 0);
    @(negedge clk); avail = 1'b1; #1;
    chk(jam, "R10 jam high on low free space", jam, 1);
    granted = 1'b0;
    repeat (10) begin
      @(negedge clk); #1;
      if (grant || pgo) granted = 1'b1;
    end
    chk(!granted && jam, "R10 no grant while jamming", granted, 0);
    @(negedge clk); rx_free = 12'd3072;
    @(negedge clk);
    wait_start(c);
    chk(!jam && grant && c == gap_clks(gap_code) + 1, "R10 gap after jam", c, gap_clks(gap_code) + 1);
    send_frame(6, 0, 0);
    settle();
  endtask

  task automatic t_jam_full();
    int c;
    full_dup = 1'b1;
    @(negedge clk); rx_free = 12'd10;
    repeat (3) @(negedge clk);
    #1;
    chk(!jam, "R11 no jam in full duplex", jam, 0);
    avail = 1'b1;
    wait_start(c);
    chk(grant && c == 1, "R11 grant despite low free space", c, 1);
    send_frame(6, 0, 0);
    rx_free = 12'd4000;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  %0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; gap_code = 4'b0000; jab_dis = 1'b0; full_dup = 1'b0;
    avail = 1'b0; fend = 1'b0; set_z = 1'b0; set_m = 1'b0;
    rx_free = 12'd4000; thresh = 12'd3072;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gap(4'b0000, "R2 code 0000");
    t_gap(4'b0111, "R2 code 0111");
    t_gap(4'b1000, "R3 code 1000");
    t_gap(4'b1011, "R3 code 1011");
    t_gap(4'b1110, "R3 code 1110");
    t_gap(4'b1111, "R3 code 1111");
    gap_code = 4'b1001;
    t_busy_ignore();
    t_jabber_on();
    t_jabber_off();
    t_pause();
    t_jam_half();
    t_jam_full();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule